// File: doc/BRIEF.md
# Write-Protected Glitch-Free System Clock Prescaler

This block derives a system clock from a source clock by a power-of-two factor between 1 and 256. Software reaches it through one 8-bit control register on a plain write strobe and data bus, with the register contents always visible on a read port. Changing the division factor is guarded: software must first write an exact unlock code, then write the new select value within a short window. A stray write therefore cannot retune the chip clock.

When a new select value is accepted, the divider lets the current high phase of the output end at its full width. It then starts the new period with a low phase of the new width, so no runt pulse appears on the output. The divided clock drives the system clock output. When a static enable is set, it also drives a clock-out pin. During reset the output follows the source clock, so downstream logic keeps receiving edges. After reset is released, the reset division setting takes over through the same switchover.

The register and the unlock timer run on the rising edge of the source clock. The divider state changes only on the falling edge, when the source is low. The register interface is plain control access with a single-cycle write strobe, and it has no back-pressure.

Top module: `sysclk_prescaler`

## Requirements
- R1: The read port shows the unlock flag in bit 7 and the 4-bit division select in bits 3:0. Bits 6:4 always read as zero.
- R2: The unlock flag is set only by a write of exactly 0x80. A write with bit 7 set and any other bit set changes neither the flag nor the select.
- R3: While the unlock flag is clear, a write with bit 7 at zero leaves the select unchanged.
- R4: After the unlock write, the flag stays set for four source clock cycles. A select write on the fourth rising edge after the unlock edge is still accepted; one on the fifth is ignored. Any write with bit 7 at zero while the flag is set clears the flag.
- R5: An accepted select value s in 0..8 divides the source by 2^s. The values 9..15 clear the flag but leave the select unchanged, so the select never holds a value above 8.
- R6: Reset is asynchronous and active low. It clears the flag and loads select 3 (divide by 8) when cfg_div8 is high, or select 0 (divide by 1) otherwise.
- R7: For a division N of 2 or more, sys_clk is high for N/2 and low for N/2 source periods. For N = 1, sys_clk is the source clock.
- R8: On a change of setting, the running high phase completes. No high or low phase is shorter than half the smaller of the old period T1 and the new period T2. The first full new period (rise to rise) ends within T1 + 2*T2 of the accepting edge.
- R9: clk_out carries sys_clk while clkout_en is high and stays low while clkout_en is low.
- R10: While reset is asserted, sys_clk and (when enabled) clk_out follow the source clock. After release, the reset select is reached through a glitch-free switchover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div8 | input | 1 | Static choice of reset division: 1 selects divide by 8, 0 selects divide by 1 |
| clkout_en | input | 1 | Static enable of the clock-out pin |
| wr_en | input | 1 | Register write strobe, sampled on the rising source edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents: flag, zero field, select |
| sys_clk | output | 1 | Divided system clock |
| clk_out | output | 1 | Clock-out pin |

## Verification
On every source cycle the assertions check the register rules. These are: the zero field, the select staying in the legal range, the flag rising only after the exact unlock code, a locked select holding still, and the unlock window never lasting past four cycles. Pulse widths, 50% duty, the switchover time bound and the clock-out pin during reset are properties of real edge times. Only the bench's scenarios show them: across a walk of select changes, including changes into and out of divide-by-1, it timestamps every output edge and checks each width.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int          REG_W        = 8;
  localparam logic [7:0]  UNLOCK_CODE  = 8'h80;
  localparam int          FLAG_BIT     = 7;
endpackage

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
  import prescale_pkg::*;
#(
  parameter int SEL_W         = 4,
  parameter int MAX_SEL       = 8,
  parameter int UNLOCK_CYCLES = 4,
  parameter int RESET_SEL_HI  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_div8,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [SEL_W-1:0] sel
);
  localparam int TMR_W = $clog2(UNLOCK_CYCLES + 1);
  localparam int PAD_W = REG_W - 1 - SEL_W;
  localparam logic [SEL_W-1:0] SEL_RST_HI = SEL_W'(RESET_SEL_HI);
  localparam logic [SEL_W-1:0] SEL_LIMIT  = SEL_W'(MAX_SEL);
  localparam logic [TMR_W-1:0] TMR_LOAD   = TMR_W'(UNLOCK_CYCLES - 1);

  logic             flag_q;
  logic [TMR_W-1:0] tmr_q;
  logic [SEL_W-1:0] sel_q;
  logic             is_unlock, is_sel_wr, sel_legal;

  // Unlock needs the exact code; a select write is any write with the flag bit low.
  assign is_unlock = wr_en && (wr_data == UNLOCK_CODE);
  assign is_sel_wr = wr_en && !wr_data[FLAG_BIT];
  assign sel_legal = wr_data[SEL_W-1:0] <= SEL_LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      tmr_q  <= '0;
      sel_q  <= cfg_div8 ? SEL_RST_HI : '0;
    end else if (is_unlock) begin
      flag_q <= 1'b1;
      tmr_q  <= TMR_LOAD;
    end else if (flag_q) begin
      if (is_sel_wr) begin
        // One write consumes the unlock; reserved codes change nothing else.
        flag_q <= 1'b0;
        if (sel_legal) sel_q <= wr_data[SEL_W-1:0];
      end else if (tmr_q == '0) begin
        flag_q <= 1'b0;
      end else begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

  assign rd_data = {flag_q, {PAD_W{1'b0}}, sel_q};
  assign sel     = sel_q;
endmodule

// File: rtl/pow2_switch_div.sv
module pow2_switch_div #(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] tgt_sel,
  output logic             clk_div
);
  localparam int CNT_W = (MAX_SEL < 2) ? 1 : MAX_SEL - 1;

  logic             bypass_q;
  logic             div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic [SEL_W-1:0] cur_q;
  logic             change;

  // Half period minus one, in source cycles, for the active select.
  always_comb begin
    half_m1 = '0;
    for (int i = 1; i <= MAX_SEL; i++) begin
      if (cur_q == SEL_W'(i)) half_m1 = CNT_W'((1 << (i - 1)) - 1);
    end
  end

  assign change = (tgt_sel != cur_q);

  // All state moves on the falling source edge, when the source is low, so
  // a swap between the bypass path and the divided path meets two low inputs.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_q <= 1'b1;
      div_q    <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
    end else if (bypass_q) begin
      if (change) begin
        cur_q <= tgt_sel;
        if (tgt_sel != '0) begin
          bypass_q <= 1'b0;
          div_q    <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end else if (cnt_q >= half_m1) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      // Only at the close of a high phase may the setting move.
      if (div_q && change) begin
        cur_q    <= tgt_sel;
        bypass_q <= (tgt_sel == '0);
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign clk_div = bypass_q ? clk : div_q;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int SEL_W         = 4,
  parameter int MAX_SEL       = 8,
  parameter int UNLOCK_CYCLES = 4,
  parameter int RESET_SEL_HI  = 3
) (
  input  logic       src_clk,
  input  logic       rst_n,
  input  logic       cfg_div8,
  input  logic       clkout_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_clk,
  output logic       clk_out
);
  logic [SEL_W-1:0] sel;

  prescale_ctrl #(
    .SEL_W(SEL_W), .MAX_SEL(MAX_SEL),
    .UNLOCK_CYCLES(UNLOCK_CYCLES), .RESET_SEL_HI(RESET_SEL_HI)
  ) u_ctrl (
    .clk(src_clk), .rst_n(rst_n), .cfg_div8(cfg_div8),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sel(sel)
  );

  pow2_switch_div #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
    .clk(src_clk), .rst_n(rst_n), .tgt_sel(sel), .clk_div(sys_clk)
  );

  assign clk_out = clkout_en & sys_clk;
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk #(
  parameter int MAX_SEL       = 8,
  parameter int UNLOCK_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data
);
  logic [7:0] open_run_q;

  // Cycles the flag has been high since the last unlock write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           open_run_q <= '0;
    else if (wr_en && wr_data == 8'h80)   open_run_q <= '0;
    else if (rd_data[7])                  open_run_q <= open_run_q + 8'd1;
    else                                  open_run_q <= '0;
  end

  p_zero_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);

  p_flag_needs_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> $past(wr_en && wr_data == 8'h80));

  p_code_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'h80) |=> rd_data[7]);

  p_locked_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |=> $stable(rd_data[3:0]));

  p_unlock_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> (open_run_q < 8'(UNLOCK_CYCLES)));

  p_select_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] <= 4'(MAX_SEL));
endmodule

bind sysclk_prescaler sysclk_prescaler_chk #(
  .MAX_SEL(MAX_SEL), .UNLOCK_CYCLES(UNLOCK_CYCLES)
) u_chk (
  .clk(src_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/sysclk_prescaler_test.sv
`timescale 1ns/1ps
module sysclk_prescaler_test;
  logic       src_clk   = 1'b0;
  logic       rst_n     = 1'b0;
  logic       cfg_div8  = 1'b1;
  logic       clkout_en = 1'b1;
  logic       wr_en     = 1'b0;
  logic [7:0] wr_data   = 8'h00;
  logic [7:0] rd_data;
  logic       sys_clk, clk_out;

  always #2 src_clk = ~src_clk;

  sysclk_prescaler uut (
    .src_clk(src_clk), .rst_n(rst_n), .cfg_div8(cfg_div8), .clkout_en(clkout_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sys_clk(sys_clk), .clk_out(clk_out)
  );

  // Each entry: {select written, select expected afterwards}.
  localparam int NVEC = 9;
  localparam logic [7:0] VEC [0:NVEC-1] = '{
    8'h00, 8'h22, 8'h55, 8'hC5, 8'h11, 8'h88, 8'h00, 8'h44, 8'h33
  };

  int      n_chk = 0, n_bad = 0, co_edges = 0, bad_w = 0, min_w = 2;
  bit      mon_on = 0, mon_seen = 0;
  realtime last_edge = 0.0, t_acc = 0.0;

  always @(posedge clk_out) co_edges++;

  // Width monitor over every edge of the system clock.
  always @(sys_clk) begin
    if (mon_on) begin
      if (mon_seen && ($realtime - last_edge) < real'(min_w) - 0.01) bad_w++;
      mon_seen = 1;
    end else begin
      mon_seen = 0;
    end
    last_edge = $realtime;
  end

  function automatic int per_ns(input int s);
    return 4 << s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge src_clk); wr_en = 1'b1; wr_data = d;
    @(posedge src_clk); t_acc = $realtime;
    @(negedge src_clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic period(output int p);
    realtime t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = $rtoi($realtime - t0 + 0.5);
  endtask

  task automatic high_w(output int w);
    realtime t0;
    @(posedge sys_clk); t0 = $realtime;
    @(negedge sys_clk); w = $rtoi($realtime - t0 + 0.5);
  endtask

  task automatic wait_new(input int t2, output int elapsed);
    realtime prev;
    int p;
    prev = -1.0e6;
    do begin
      @(posedge sys_clk);
      p = $rtoi($realtime - prev + 0.5);
      prev = $realtime;
    end while (p != t2);
    elapsed = $rtoi($realtime - t_acc + 0.5);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #700000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int p, w, el, t1, t2, cur;
    // R10: the clock-out pin runs at the source rate while reset is held.
    repeat (20) @(negedge src_clk);
    check(co_edges >= 19, "R10 clk_out edges during reset", co_edges, 20);
    // R6 / R1: reset contents with cfg_div8 high.
    check(rd_data == 8'h03, "R6 reset register (div8)", rd_data, 8'h03);
    rst_n = 1'b1;
    repeat (100) @(negedge src_clk);
    period(p);
    check(p == 32, "R6 reset division 8 after release", p, 32);
    mon_on = 1; min_w = 16;

    // R3: a select write without unlock is ignored.
    wr(8'h05);
    check(rd_data == 8'h03, "R3 locked select write", rd_data, 8'h03);
    // R2: bit 7 plus another bit does not unlock.
    wr(8'h81);
    check(rd_data == 8'h03, "R2 near-miss unlock code", rd_data, 8'h03);
    wr(8'h05);
    check(rd_data == 8'h03, "R2 select after near-miss", rd_data, 8'h03);
    period(p);
    check(p == 32, "R3 division unchanged", p, 32);

    // R4: flag lasts four cycles, then drops.
    wr(8'h80);
    check(rd_data[7] == 1'b1, "R4 flag set after unlock", rd_data[7], 1);
    repeat (3) @(negedge src_clk);
    check(rd_data[7] == 1'b1, "R4 flag after third cycle", rd_data[7], 1);
    @(negedge src_clk);
    check(rd_data[7] == 1'b0, "R4 flag expired", rd_data[7], 0);

    // R4: write on the fourth following edge is accepted.
    min_w = 4;
    wr(8'h80);
    repeat (2) @(negedge src_clk);
    wr(8'h01);
    check(rd_data == 8'h01, "R4 write on last window edge", rd_data, 8'h01);
    // R4: write on the fifth following edge is ignored.
    wr(8'h80);
    repeat (3) @(negedge src_clk);
    wr(8'h04);
    check(rd_data == 8'h01, "R4 write after window", rd_data, 8'h01);
    repeat (100) @(negedge src_clk);
    period(p);
    check(p == 8, "R5 division 2 in effect", p, 8);
    cur = 1;

    // Table walk: R5, R7, R8.
    for (int i = 0; i < NVEC; i++) begin
      int ws, es;
      ws = int'(VEC[i][7:4]);
      es = int'(VEC[i][3:0]);
      t1 = per_ns(cur);
      t2 = per_ns(es);
      min_w = ((t1 < t2) ? t1 : t2) / 2;
      bad_w = 0;
      wr(8'h80);
      wr(8'(ws));
      check(rd_data == 8'(es), "R5 select after write", rd_data, es);
      if (es != cur) begin
        wait_new(t2, el);
        check(el <= t1 + 2 * t2, "R8 switchover bound", el, t1 + 2 * t2);
        period(p);
        check(p == t2, "R7 steady period", p, t2);
        high_w(w);
        check(w == t2 / 2, "R7 high width", w, t2 / 2);
      end else begin
        period(p);
        check(p == t1, "R5 reserved keeps division", p, t1);
      end
      check(bad_w == 0, "R8 no short pulse", bad_w, 0);
      cur = es;
    end

    // R9: gated clock-out pin.
    clkout_en = 1'b0;
    co_edges = 0;
    repeat (50) @(negedge src_clk);
    check(co_edges == 0, "R9 clk_out held low", co_edges, 0);
    clkout_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge src_clk); #1;
      check(clk_out == sys_clk, "R9 clk_out follows sys_clk", clk_out, sys_clk);
    end

    // R6: second reset with cfg_div8 low gives divide by 1.
    mon_on = 0;
    @(negedge src_clk); rst_n = 1'b0; cfg_div8 = 1'b0;
    @(negedge src_clk);
    check(rd_data == 8'h00, "R6 reset register (div1)", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (20) @(negedge src_clk);
    period(p);
    check(p == 4, "R7 divide by 1 period", p, 4);
    high_w(w);
    check(w == 2, "R7 divide by 1 high width", w, 2);
    finish_run();
  end
endmodule